// File: doc/BRIEF.md
# Suspendable Block-Erase Sequencer

This block runs the block-erase operation of a single NAND die as a timed chain of phases. First comes a long erase-voltage pulse. Then a discharge of the wire voltage brings the well back to a safe level. A verify phase ends the chain. All phase lengths are parameters counted in clock cycles. For example, a 1.5 ms or 3 ms pulse at 100 MHz becomes 150,000 or 300,000 cycles.

A read waiting for the same die can preempt the erase by holding a level input high:

- **Pulse interrupted:** the pulse stops and the cycles it has already delivered are banked. The well is discharged for the full discharge time, and only then does the sequencer report that it is suspended. After the read finishes, only the leftover pulse cycles are applied.
- **Discharge under way:** the discharge always finishes in full before the die is handed over.
- **Verify interrupted:** the verify is dropped at once and, on resume, runs again from its first cycle.

Completion is flagged only by a verify that runs to its end without interruption.

States and transitions. IDLE→PULSE on a start command. PULSE→DISCHARGE when the last pulse cycle is delivered or a read is pending. DISCHARGE→SUSPEND at the end of the discharge when pulse time is still owed or a read is pending. DISCHARGE→VERIFY at the end of the discharge otherwise. VERIFY→SUSPEND when a read is pending. VERIFY→IDLE on the last verify cycle, with the done pulse. SUSPEND→PULSE on read-done when pulse time is still owed. SUSPEND→VERIFY on read-done otherwise.

Top module: `erase_sequencer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `status` is 0 and every phase enable, `busy`, `suspended` and `erase_done` are low.
- R2: A `start_erase` seen in IDLE puts the sequencer in PULSE in the next cycle, with `erase_pulse_en` and `busy` high.
- R3: Without reads, the sequence is PULSE for PULSE_CYCLES cycles, then DISCHARGE for DISCHARGE_CYCLES cycles, then VERIFY for VERIFY_CYCLES cycles. The cycle after that is IDLE with `erase_done` high.
- R4: Every DISCHARGE visit lasts exactly DISCHARGE_CYCLES cycles, whatever `read_pending` does.
- R5: A read pending in pulse cycle k (counting from 0) ends the pulse after that cycle. DISCHARGE follows, then SUSPEND. After resume only the missing pulse cycles are applied, so the total number of `erase_pulse_en` cycles is always PULSE_CYCLES.
- R6: A read pending during DISCHARGE, or in the last pulse cycle, leads to SUSPEND after the full discharge. The resume then goes to VERIFY.
- R7: A read pending in a VERIFY cycle gives SUSPEND in the next cycle. On resume, VERIFY runs again for a full VERIFY_CYCLES cycles.
- R8: SUSPEND holds until `read_done` is seen. The next cycle is PULSE if pulse time is owed, otherwise VERIFY.
- R9: `erase_done` is high for exactly one cycle, directly after the last cycle of an uninterrupted VERIFY.
- R10: `start_erase` has no effect while `busy` is high: neither the pulse total nor the completion time changes.
- R11: `status` encodes IDLE=0, PULSE=1, DISCHARGE=2, VERIFY=3, SUSPEND=4. Each value matches the phase enable that is high, or `suspended`.
- R12: At most one of `erase_pulse_en`, `wire_reset_en`, `verify_en` and `suspended` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_erase | input | 1 | Start a block erase (acted on in IDLE only) |
| read_pending | input | 1 | Level request from a waiting read |
| read_done | input | 1 | One-cycle pulse when the read has finished |
| busy | output | 1 | High in every state except IDLE |
| suspended | output | 1 | Die is handed over to the read |
| erase_pulse_en | output | 1 | Apply erase voltage to the block |
| wire_reset_en | output | 1 | Discharge the wire voltage |
| verify_en | output | 1 | Run erase verify |
| erase_done | output | 1 | One-cycle completion pulse |
| status | output | 3 | Current phase code |

## Verification
All outputs are registered from the next state, so a change at an input shows on the outputs one cycle later:

| Input event | Output result |
|---|---|
| Start | PULSE in the next cycle |
| Read in verify | SUSPEND in the next cycle |
| `read_done` | Resume phase in the next cycle |
| Read in pulse cycle k | SUSPEND in cycle k+1+DISCHARGE_CYCLES |
| Read in discharge | SUSPEND in the first cycle after the discharge |

The bench sweeps the cycle at which a read arrives across every cycle of one erase, plus a run with no read. It works out the suspend cycle and the completion cycle from these sums. Inputs are driven and outputs sampled at the falling edge, so each sample falls in the cycle the arithmetic predicts.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_PULSE     = 3'd1,
        ST_DISCHARGE = 3'd2,
        ST_VERIFY    = 3'd3,
        ST_SUSPEND   = 3'd4
    } erase_state_e;

    typedef struct packed {
        logic busy;
        logic suspended;
        logic pulse_en;
        logic discharge_en;
        logic verify_en;
    } phase_drive_t;

    function automatic phase_drive_t decode_state(erase_state_e st);
        phase_drive_t d;
        d = '0;
        d.busy         = (st != ST_IDLE);
        d.suspended    = (st == ST_SUSPEND);
        d.pulse_en     = (st == ST_PULSE);
        d.discharge_en = (st == ST_DISCHARGE);
        d.verify_en    = (st == ST_VERIFY);
        return d;
    endfunction

endpackage

// File: rtl/erase_pulse_ledger.sv
// Holds the pulse cycles still owed to the current erase.
module erase_pulse_ledger #(
    parameter int CYCLES = 150000,
    parameter int W      = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic consume,
    output logic owed_zero,
    output logic owed_last
);
    localparam logic [W-1:0] FULL = W'(CYCLES);

    logic [W-1:0] owed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            owed_q <= '0;
        end else if (load) begin
            owed_q <= FULL;
        end else if (consume && owed_q != '0) begin
            owed_q <= owed_q - 1'b1;
        end
    end

    assign owed_zero = (owed_q == '0);
    assign owed_last = (owed_q == W'(1));
endmodule

// File: rtl/phase_timer.sv
// Counts cycles spent in a timed phase; restarts on every phase entry.
module phase_timer #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         last
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last = run && (cnt_q == limit - 1'b1);
endmodule

// File: rtl/erase_sequencer.sv
module erase_sequencer
    import erase_seq_pkg::*;
#(
    parameter int PULSE_CYCLES     = 150000,
    parameter int DISCHARGE_CYCLES = 400,
    parameter int VERIFY_CYCLES    = 800
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_erase,
    input  logic       read_pending,
    input  logic       read_done,
    output logic       busy,
    output logic       suspended,
    output logic       erase_pulse_en,
    output logic       wire_reset_en,
    output logic       verify_en,
    output logic       erase_done,
    output logic [2:0] status
);
    localparam int LONGEST = (DISCHARGE_CYCLES > VERIFY_CYCLES) ? DISCHARGE_CYCLES : VERIFY_CYCLES;
    localparam int TW      = $clog2(LONGEST + 1);
    localparam int PW      = $clog2(PULSE_CYCLES + 1);

    erase_state_e state_q, state_d;
    logic         owed_zero, owed_last;
    logic         timer_last;
    logic [TW-1:0] timer_limit;
    logic         timed_phase;
    phase_drive_t drive;

    erase_pulse_ledger #(.CYCLES(PULSE_CYCLES), .W(PW)) u_ledger (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (state_q == ST_IDLE && start_erase),
        .consume   (state_q == ST_PULSE),
        .owed_zero (owed_zero),
        .owed_last (owed_last)
    );

    assign timed_phase = (state_q == ST_DISCHARGE) || (state_q == ST_VERIFY);
    assign timer_limit = (state_q == ST_DISCHARGE) ? TW'(DISCHARGE_CYCLES) : TW'(VERIFY_CYCLES);

    phase_timer #(.W(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (state_d != state_q),
        .run     (timed_phase),
        .limit   (timer_limit),
        .last    (timer_last)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_erase) state_d = ST_PULSE;
            end
            ST_PULSE: begin
                if (read_pending || owed_last) state_d = ST_DISCHARGE;
            end
            ST_DISCHARGE: begin
                if (timer_last) begin
                    if (!owed_zero || read_pending) state_d = ST_SUSPEND;
                    else                            state_d = ST_VERIFY;
                end
            end
            ST_VERIFY: begin
                if (read_pending)    state_d = ST_SUSPEND;
                else if (timer_last) state_d = ST_IDLE;
            end
            ST_SUSPEND: begin
                if (read_done) state_d = owed_zero ? ST_VERIFY : ST_PULSE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Registered outputs, aligned with the state register
    assign drive = decode_state(state_d);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy           <= 1'b0;
            suspended      <= 1'b0;
            erase_pulse_en <= 1'b0;
            wire_reset_en  <= 1'b0;
            verify_en      <= 1'b0;
            erase_done     <= 1'b0;
            status         <= 3'd0;
        end else begin
            busy           <= drive.busy;
            suspended      <= drive.suspended;
            erase_pulse_en <= drive.pulse_en;
            wire_reset_en  <= drive.discharge_en;
            verify_en      <= drive.verify_en;
            erase_done     <= (state_q == ST_VERIFY) && (state_d == ST_IDLE);
            status         <= state_d;
        end
    end
endmodule

// File: rtl/erase_sequencer_chk.sv
module erase_sequencer_chk #(
    parameter int DISCHARGE_CYCLES = 400
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start_erase,
    input logic       read_done,
    input logic       busy,
    input logic       suspended,
    input logic       erase_pulse_en,
    input logic       wire_reset_en,
    input logic       verify_en,
    input logic       erase_done
);
    localparam int CW = $clog2(DISCHARGE_CYCLES + 2);

    logic [CW-1:0] dis_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             dis_run <= '0;
        else if (wire_reset_en) dis_run <= dis_run + 1'b1;
        else                    dis_run <= '0;
    end

    // R12
    phase_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({erase_pulse_en, wire_reset_en, verify_en, suspended}));

    // R5
    pulse_then_discharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(erase_pulse_en) |-> wire_reset_en);

    // R4
    discharge_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wire_reset_en) |-> (dis_run == CW'(DISCHARGE_CYCLES)));

    // R6
    no_charged_handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(suspended) |-> !$past(erase_pulse_en));

    // R8
    suspend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (suspended && !read_done) |=> suspended);

    // R9
    done_after_verify_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_done |-> ($past(verify_en) && !busy));

    // R10
    start_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start_erase) |=> (busy || erase_done));
endmodule

bind erase_sequencer erase_sequencer_chk #(.DISCHARGE_CYCLES(DISCHARGE_CYCLES)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_erase    (start_erase),
    .read_done      (read_done),
    .busy           (busy),
    .suspended      (suspended),
    .erase_pulse_en (erase_pulse_en),
    .wire_reset_en  (wire_reset_en),
    .verify_en      (verify_en),
    .erase_done     (erase_done)
);

// File: tb/erase_sequencer_test.sv
module erase_sequencer_test;
    localparam int P    = 6;
    localparam int R    = 3;
    localparam int V    = 4;
    localparam int HOLD = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_erase = 1'b0;
    logic       read_pending = 1'b0;
    logic       read_done = 1'b0;
    logic       busy, suspended, erase_pulse_en, wire_reset_en, verify_en, erase_done;
    logic [2:0] status;

    int checks = 0;
    int fails = 0;
    int total_cycles = 0;

    always #5 clk = ~clk;

    erase_sequencer #(
        .PULSE_CYCLES(P), .DISCHARGE_CYCLES(R), .VERIFY_CYCLES(V)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start_erase(start_erase),
        .read_pending(read_pending), .read_done(read_done),
        .busy(busy), .suspended(suspended), .erase_pulse_en(erase_pulse_en),
        .wire_reset_en(wire_reset_en), .verify_en(verify_en),
        .erase_done(erase_done), .status(status)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int code_of(input logic pe, input logic de, input logic ve, input logic su);
        if (pe) return 1;
        if (de) return 2;
        if (ve) return 3;
        if (su) return 4;
        return 0;
    endfunction

    // t < 0: no read during this erase
    task automatic run_case(input int t);
        int  pulses = 0;
        int  susp_at = -1;
        int  susp_len = 0;
        int  done_at = -1;
        int  dis_run = 0;
        int  resume_at = -1;
        int  exp_susp = -1;
        int  exp_done;
        bit  exp_resume_pulse = 1'b0;
        string sreq;
        if (t < 0) begin
            exp_done = P + R + V; sreq = "R3";
        end else if (t < P - 1) begin
            exp_susp = t + 1 + R; exp_resume_pulse = 1'b1;
            exp_done = exp_susp + HOLD + 1 + (P - t - 1) + R + V; sreq = "R5";
        end else if (t < P + R) begin
            exp_susp = P + R;
            exp_done = exp_susp + HOLD + 1 + V; sreq = "R6";
        end else begin
            exp_susp = t + 1;
            exp_done = exp_susp + HOLD + 1 + V; sreq = "R7";
        end

        @(negedge clk); start_erase = 1'b1;
        @(negedge clk); start_erase = 1'b0;
        for (int cyc = 0; cyc < 200 && done_at < 0; cyc++) begin
            if (cyc > 0) @(negedge clk);
            if (cyc == 0) check(erase_pulse_en && busy, "R2", {erase_pulse_en, busy}, 3);
            check($countones({erase_pulse_en, wire_reset_en, verify_en, suspended}) <= 1,
                  "R12", $countones({erase_pulse_en, wire_reset_en, verify_en, suspended}), 1);
            check(int'(status) == code_of(erase_pulse_en, wire_reset_en, verify_en, suspended),
                  "R11", status, code_of(erase_pulse_en, wire_reset_en, verify_en, suspended));
            if (erase_pulse_en) pulses++;
            if (wire_reset_en) dis_run++;
            else if (dis_run > 0) begin
                check(dis_run == R, "R4", dis_run, R);
                dis_run = 0;
            end
            if (erase_done) done_at = cyc;
            if (suspended) begin
                if (susp_at < 0) susp_at = cyc;
                susp_len++;
            end
            if (cyc == resume_at)
                check(exp_resume_pulse ? erase_pulse_en : verify_en, "R8",
                      {erase_pulse_en, verify_en}, exp_resume_pulse ? 2 : 1);
            // drive for this cycle
            read_pending = (t >= 0) && (cyc >= t) && (susp_at < 0);
            start_erase  = (cyc == 1) || (susp_len == 1);
            read_done    = suspended && (susp_len == HOLD + 1);
            if (read_done) resume_at = cyc + 1;
        end
        if (done_at < 0) check(1'b0, "R3 timeout", done_at, exp_done);
        start_erase = 1'b0; read_pending = 1'b0; read_done = 1'b0;
        check(susp_at == exp_susp, sreq, susp_at, exp_susp);
        check(done_at == exp_done, (t < 0) ? "R3" : sreq, done_at, exp_done);
        check(pulses == P, "R5 R10", pulses, P);
        check(susp_len == ((t < 0) ? 0 : HOLD + 1), "R8", susp_len, (t < 0) ? 0 : HOLD + 1);
        @(negedge clk);
        check(!erase_done && !busy && status == 3'd0, "R9", {erase_done, busy, status}, 0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            total_cycles++;
            if (total_cycles > 100000) begin
                fails++;
                $display("FAIL watchdog actual=%0d expected=%0d", total_cycles, 100000);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(status == 3'd0 && !busy && !erase_pulse_en && !wire_reset_en && !verify_en
              && !suspended && !erase_done, "R1", status, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(status == 3'd0 && !busy && !erase_done, "R1", status, 0);
        for (int t = -1; t < P + R + V; t++) run_case(t);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule